// File: doc/BRIEF.md
# Configuration Unlock Key Detector

This block monitors byte writes to the configuration address port and recognises two unlock sequences. Each sequence is 32 bytes long, and an 8-bit shift register derives each byte from the one before it. One sequence is the standard plug-and-play unlock key. The other is a vendor-private key. Both sequences are tracked in parallel.

Two policy inputs decide which match is allowed to unlock the card:
- a flag reporting whether the configuration EEPROM loaded correctly;
- a legacy-mode flag that hides the card from generic configuration software.

When an allowed sequence completes, the block raises a single-cycle pulse. A qualifier bit on that pulse tells which key matched. The surrounding configuration state machine reports whether it is waiting for a key. Outside that state, the detector ignores the port.

Top module: `init_key_detect`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `unlock` and `unlock_vendor` are 0.
- R2: Each key has 32 bytes, and each byte after the first is derived from the previous byte. The derivation shifts the previous byte right by one place and puts the XOR of its old bits 0 and 1 into bit 7. The standard key starts with 0x6A, 0xB5, 0xDA. The vendor key starts with 0x6B, 0x35, 0x9A.
- R3: A key byte is taken only in a cycle where `io_wr` is 1 and `io_addr` equals 0x0279. Cycles without a write, and writes to any other address, neither advance nor break a partial match.
- R4: Only `io_data[7:0]` is compared. The value of `io_data[15:8]` has no effect.
- R5: If a port write carries a byte other than the expected one, that key's match restarts. If the byte equals the key's first byte, it counts as byte 1 of a new attempt.
- R6: Two port writes of 0x00 in a row return both keys to their start. A key completed after that pair must be sent from its first byte.
- R7: When `legacy_mode` is 1, a completed standard key is ignored and a completed vendor key is accepted.
- R8: When `legacy_mode` is 0 and `eeprom_good` is 1, only the standard key is accepted. When `legacy_mode` is 0 and `eeprom_good` is 0, only the vendor key is accepted.
- R9: An accepted key raises `unlock` for exactly one cycle, in the cycle after the clock edge that samples the 32nd byte. `unlock_vendor` is 1 with that pulse for the vendor key and 0 for the standard key. At all other times `unlock_vendor` is 0.
- R10: Detection happens only while `wait_key` is 1. While `wait_key` is 0, port writes are ignored and both keys return to their start.
- R11: After a key completes, its match restarts from the first byte. The same key sent twice in a row therefore gives two pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_addr | input | 16 | I/O write address |
| io_data | input | 16 | I/O write data; only the low byte is used |
| eeprom_good | input | 1 | EEPROM contents loaded without error |
| legacy_mode | input | 1 | Standard key locked out when 1 |
| wait_key | input | 1 | Configuration state machine is waiting for a key |
| unlock | output | 1 | One-cycle pulse when an allowed key completes |
| unlock_vendor | output | 1 | 1 with `unlock` when the vendor key matched |

## Verification
The bench builds the block with its default parameters:
- 32-byte keys;
- port 0x0279;
- seeds 0x6A and 0x6B.

With these values, the full-length keys are reachable, together with every position at which a break, a zero pair or a reseed can fall. A behavioural model derives both keys from their seeds and follows every port write byte by byte. The model covers all four combinations of the EEPROM and legacy flags. It is also driven through interleaved foreign writes, high-byte noise and a gap in the wait state.

// File: rtl/ikd_pkg.sv
package ikd_pkg;
  localparam int BYTE_W = 8;

  typedef logic [BYTE_W-1:0] kbyte_t;

  typedef enum logic {
    KEY_STD = 1'b0,
    KEY_VND = 1'b1
  } key_id_e;

  // Advance the key generator by one byte.
  function automatic kbyte_t key_advance(input kbyte_t v);
    return {v[0] ^ v[1], v[BYTE_W-1:1]};
  endfunction
endpackage

// File: rtl/ikd_port_decode.sv
module ikd_port_decode
  import ikd_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 16,
  parameter logic [15:0] PORT_ADDR = 16'h0279
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              active,
  output logic              byte_vld,
  output kbyte_t            byte_val,
  output logic              zero_pair
);
  localparam logic [ADDR_W-1:0] PORT_A = ADDR_W'(PORT_ADDR);

  logic prev_zero_q;
  logic prev_zero_d;
  logic prev_zero_en;
  logic is_zero;

  always_comb begin
    byte_vld     = active && wr && (addr == PORT_A);
    byte_val     = data[BYTE_W-1:0];
    is_zero      = (byte_val == '0);
    zero_pair    = byte_vld && is_zero && prev_zero_q;
    prev_zero_en = byte_vld || !active;
    prev_zero_d  = active && is_zero && !zero_pair;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_zero_q <= 1'b0;
    end else if (prev_zero_en) begin
      prev_zero_q <= prev_zero_d;
    end
  end
endmodule

// File: rtl/ikd_tracker.sv
module ikd_tracker
  import ikd_pkg::*;
#(
  parameter int     KEY_LEN = 32,
  parameter kbyte_t SEED    = 8'h6A
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   restart,
  input  logic   byte_vld,
  input  kbyte_t byte_val,
  output logic   hit
);
  localparam int           CW   = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(KEY_LEN - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  kbyte_t        exp_q, exp_d;
  logic          upd_en;
  logic          match;
  logic          at_last;

  always_comb begin
    match   = (byte_val == exp_q);
    at_last = (cnt_q == LAST);
    hit     = byte_vld && !restart && match && at_last;
    upd_en  = restart || byte_vld;
    cnt_d   = cnt_q;
    exp_d   = exp_q;
    if (restart) begin
      cnt_d = '0;
      exp_d = SEED;
    end else if (match && at_last) begin
      cnt_d = '0;
      exp_d = SEED;
    end else if (match) begin
      cnt_d = cnt_q + 1'b1;
      exp_d = key_advance(exp_q);
    end else if (byte_val == SEED) begin
      cnt_d = CW'(1);
      exp_d = key_advance(SEED);
    end else begin
      cnt_d = '0;
      exp_d = SEED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= SEED;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end
endmodule

// File: rtl/ikd_grant.sv
module ikd_grant
  import ikd_pkg::*;
(
  input  logic       eeprom_good,
  input  logic       legacy_mode,
  input  logic [1:0] hit,
  output logic       grant,
  output key_id_e    grant_id
);
  logic allow_std;
  logic allow_vnd;

  always_comb begin
    allow_std = !legacy_mode && eeprom_good;
    allow_vnd = legacy_mode || !eeprom_good;
    grant     = 1'b0;
    grant_id  = KEY_STD;
    if (hit[KEY_VND] && allow_vnd) begin
      grant    = 1'b1;
      grant_id = KEY_VND;
    end else if (hit[KEY_STD] && allow_std) begin
      grant    = 1'b1;
      grant_id = KEY_STD;
    end
  end
endmodule

// File: rtl/init_key_detect.sv
module init_key_detect
  import ikd_pkg::*;
#(
  parameter int          KEY_LEN   = 32,
  parameter logic [15:0] PORT_ADDR = 16'h0279,
  parameter logic [7:0]  STD_SEED  = 8'h6A,
  parameter logic [7:0]  VND_SEED  = 8'h6B
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_wr,
  input  logic [15:0] io_addr,
  input  logic [15:0] io_data,
  input  logic        eeprom_good,
  input  logic        legacy_mode,
  input  logic        wait_key,
  output logic        unlock,
  output logic        unlock_vendor
);
  localparam int NKEYS = 2;

  logic       byte_vld;
  kbyte_t     byte_val;
  logic       zero_pair;
  logic       restart;
  logic [NKEYS-1:0] hit;
  logic       grant;
  key_id_e    grant_id;

  logic unlock_q, unlock_d;
  logic vnd_q, vnd_d;

  ikd_port_decode #(
    .ADDR_W   (16),
    .DATA_W   (16),
    .PORT_ADDR(PORT_ADDR)
  ) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (io_wr),
    .addr     (io_addr),
    .data     (io_data),
    .active   (wait_key),
    .byte_vld (byte_vld),
    .byte_val (byte_val),
    .zero_pair(zero_pair)
  );

  assign restart = !wait_key || zero_pair;

  for (genvar g = 0; g < NKEYS; g++) begin : g_trk
    ikd_tracker #(
      .KEY_LEN(KEY_LEN),
      .SEED   ((g == int'(KEY_VND)) ? VND_SEED : STD_SEED)
    ) u_trk (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .byte_vld(byte_vld),
      .byte_val(byte_val),
      .hit     (hit[g])
    );
  end

  ikd_grant u_grant (
    .eeprom_good(eeprom_good),
    .legacy_mode(legacy_mode),
    .hit        (hit),
    .grant      (grant),
    .grant_id   (grant_id)
  );

  always_comb begin
    unlock_d = grant;
    vnd_d    = grant && (grant_id == KEY_VND);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlock_q <= 1'b0;
      vnd_q    <= 1'b0;
    end else begin
      unlock_q <= unlock_d;
      vnd_q    <= vnd_d;
    end
  end

  assign unlock        = unlock_q;
  assign unlock_vendor = vnd_q;
endmodule

// File: rtl/ikd_checker.sv
module ikd_checker #(
  parameter logic [15:0] PORT_ADDR = 16'h0279
) (
  input logic        clk,
  input logic        rst_n,
  input logic        io_wr,
  input logic [15:0] io_addr,
  input logic [15:0] io_data,
  input logic        eeprom_good,
  input logic        legacy_mode,
  input logic        wait_key,
  input logic        unlock,
  input logic        unlock_vendor
);
  // R9
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unlock |=> !unlock);

  // R9
  sel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unlock |-> !unlock_vendor);

  // R3
  src_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unlock |-> $past(io_wr && (io_addr == PORT_ADDR)));

  // R10
  src_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unlock |-> $past(wait_key));

  // R6
  zero_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unlock |-> ($past(io_data[7:0]) != 8'h00));

  // R7
  legacy_vnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock && $past(legacy_mode)) |-> unlock_vendor);

  // R8
  std_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock && !unlock_vendor) |-> $past(eeprom_good && !legacy_mode));

  // R8
  vnd_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock && unlock_vendor) |-> $past(legacy_mode || !eeprom_good));
endmodule

bind init_key_detect ikd_checker #(.PORT_ADDR(PORT_ADDR)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .io_wr        (io_wr),
  .io_addr      (io_addr),
  .io_data      (io_data),
  .eeprom_good  (eeprom_good),
  .legacy_mode  (legacy_mode),
  .wait_key     (wait_key),
  .unlock       (unlock),
  .unlock_vendor(unlock_vendor)
);

// File: tb/sim_init_key_detect.sv
`timescale 1ns/1ps
module sim_init_key_detect;
  logic        clk;
  logic        rst_n;
  logic        io_wr;
  logic [15:0] io_addr;
  logic [15:0] io_data;
  logic        eeprom_good;
  logic        legacy_mode;
  logic        wait_key;
  logic        unlock;
  logic        unlock_vendor;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] std_k [32];
  logic [7:0] vnd_k [32];

  // reference model state
  int m_ps = 0, m_pv = 0;
  bit m_prev0 = 0;
  bit m_ok = 0, m_sel = 0;
  int n_s = 0, n_v = 0, s0 = 0, v0 = 0;

  init_key_detect u0 (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_data(io_data), .eeprom_good(eeprom_good), .legacy_mode(legacy_mode),
    .wait_key(wait_key), .unlock(unlock), .unlock_vendor(unlock_vendor)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] nxt(input logic [7:0] v);
    logic [7:0] r;
    r = v >> 1;
    r[7] = v[0] ^ v[1];
    return r;
  endfunction

  initial begin
    std_k[0] = 8'h6A;
    vnd_k[0] = 8'h6B;
    for (int i = 1; i < 32; i++) begin
      std_k[i] = nxt(std_k[i-1]);
      vnd_k[i] = nxt(vnd_k[i-1]);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural model, updated on each edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ps = 0; m_pv = 0; m_prev0 = 0; m_ok = 0; m_sel = 0;
    end else begin
      bit hs, hv;
      logic [7:0] b;
      hs = 0; hv = 0;
      m_ok = 0; m_sel = 0;
      if (!wait_key) begin
        m_ps = 0; m_pv = 0; m_prev0 = 0;
      end else if (io_wr && io_addr == 16'h0279) begin
        b = io_data[7:0];
        if (m_prev0 && b == 8'h00) begin
          m_ps = 0; m_pv = 0; m_prev0 = 0;
        end else begin
          m_prev0 = (b == 8'h00);
          if (b == std_k[m_ps]) begin
            m_ps++;
            if (m_ps == 32) begin m_ps = 0; hs = 1; end
          end else m_ps = (b == std_k[0]) ? 1 : 0;
          if (b == vnd_k[m_pv]) begin
            m_pv++;
            if (m_pv == 32) begin m_pv = 0; hv = 1; end
          end else m_pv = (b == vnd_k[0]) ? 1 : 0;
        end
        if (hv && (legacy_mode || !eeprom_good)) begin m_ok = 1; m_sel = 1; end
        else if (hs && !legacy_mode && eeprom_good) m_ok = 1;
      end
    end
  end

  // compare against the model away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(unlock == m_ok, "R9 unlock vs model", unlock, m_ok);
      chk(unlock_vendor == m_sel, "R9 unlock_vendor vs model", unlock_vendor, m_sel);
      if (unlock) begin
        if (unlock_vendor) n_v++; else n_s++;
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_data = d;
    @(negedge clk);
    io_wr = 1'b0; io_addr = 16'h0000; io_data = 16'h0000;
  endtask

  task automatic send(input bit vnd, input int first, input int last,
                      input logic [7:0] hi, input bit noise);
    for (int i = first; i <= last; i++) begin
      wr(16'h0279, {hi, vnd ? vnd_k[i] : std_k[i]});
      if (noise) begin
        wr(16'h0A79, 16'h0055);
        wr(16'h0278, 16'h0000);
        @(negedge clk);
        io_wr = 1'b0; io_addr = 16'h0279; io_data = 16'h00EE;
        @(negedge clk);
        io_addr = 16'h0000; io_data = 16'h0000;
      end
    end
  endtask

  task automatic snap();
    repeat (2) @(negedge clk);
    s0 = n_s; v0 = n_v;
  endtask

  task automatic expect_n(input int ds, input int dv, input string req);
    repeat (2) @(negedge clk);
    chk((n_s - s0) == ds, {req, " standard pulses"}, n_s - s0, ds);
    chk((n_v - v0) == dv, {req, " vendor pulses"}, n_v - v0, dv);
  endtask

  task automatic zeros();
    wr(16'h0279, 16'h0000);
    wr(16'h0279, 16'h0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; io_wr = 1'b0; io_addr = '0; io_data = '0;
    eeprom_good = 1'b1; legacy_mode = 1'b0; wait_key = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(unlock == 1'b0, "R1 unlock in reset", unlock, 0);
    chk(unlock_vendor == 1'b0, "R1 unlock_vendor in reset", unlock_vendor, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(unlock == 1'b0 && unlock_vendor == 1'b0, "R1 after release", unlock, 0);

    // R2 R8 R9: standard key accepted with good EEPROM, pulse timing
    snap(); zeros();
    send(0, 0, 31, 8'h00, 0);
    chk(unlock == 1'b1, "R9 pulse after 32nd byte", unlock, 1);
    chk(unlock_vendor == 1'b0, "R9 standard qualifier", unlock_vendor, 0);
    @(negedge clk);
    chk(unlock == 1'b0, "R9 pulse width", unlock, 0);
    expect_n(1, 0, "R2");

    // R8: vendor key refused with good EEPROM
    snap(); zeros(); send(1, 0, 31, 8'h00, 0); expect_n(0, 0, "R8 vendor refused");

    // R8: bad EEPROM, vendor accepted, standard refused
    eeprom_good = 1'b0;
    snap(); zeros(); send(1, 0, 31, 8'h00, 0);
    chk(unlock == 1'b1 && unlock_vendor == 1'b1, "R8 vendor qualifier", unlock_vendor, 1);
    expect_n(0, 1, "R8 vendor accepted");
    snap(); zeros(); send(0, 0, 31, 8'h00, 0); expect_n(0, 0, "R8 standard refused");

    // R7: legacy mode with good EEPROM
    eeprom_good = 1'b1; legacy_mode = 1'b1;
    snap(); zeros(); send(0, 0, 31, 8'h00, 0); expect_n(0, 0, "R7 standard ignored");
    snap(); zeros(); send(1, 0, 31, 8'h00, 0); expect_n(0, 1, "R7 vendor accepted");
    eeprom_good = 1'b0;
    snap(); zeros(); send(1, 0, 31, 8'h00, 0); expect_n(0, 1, "R7 vendor bad eeprom");
    eeprom_good = 1'b1; legacy_mode = 1'b0;

    // R4: upper byte noise
    snap(); zeros(); send(0, 0, 31, 8'hA5, 0); expect_n(1, 0, "R4");

    // R3: foreign writes and idle port cycles between key bytes
    snap(); zeros(); send(0, 0, 31, 8'h00, 1); expect_n(1, 0, "R3");

    // R5: a wrong byte breaks the match
    snap(); zeros(); send(0, 0, 9, 8'h00, 0);
    wr(16'h0279, 16'h0011);
    send(0, 10, 31, 8'h00, 0); expect_n(0, 0, "R5 broken");
    // R5: seed byte restarts as byte 1
    snap(); zeros(); send(0, 0, 4, 8'h00, 0);
    send(0, 0, 31, 8'h00, 0); expect_n(1, 0, "R5 reseed");

    // R6: zero pair returns to start
    snap(); send(0, 0, 9, 8'h00, 0); zeros();
    send(0, 10, 31, 8'h00, 0); expect_n(0, 0, "R6 no resume");
    snap(); send(0, 0, 9, 8'h00, 0); zeros();
    send(0, 0, 31, 8'h00, 0); expect_n(1, 0, "R6 full key");

    // R10: not waiting for a key
    wait_key = 1'b0;
    snap(); zeros(); send(0, 0, 31, 8'h00, 0); expect_n(0, 0, "R10 inactive");
    wait_key = 1'b1;
    snap(); zeros(); send(0, 0, 15, 8'h00, 0);
    @(negedge clk); wait_key = 1'b0;
    @(negedge clk); wait_key = 1'b1;
    send(0, 16, 31, 8'h00, 0); expect_n(0, 0, "R10 gap restarts");

    // R11: key sent twice gives two pulses
    snap(); zeros(); send(0, 0, 31, 8'h00, 0); send(0, 0, 31, 8'h00, 0);
    expect_n(2, 0, "R11");

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule